// File: doc/BRIEF.md
# Command FIFO Status Controller

This block sits between the host and a raster drawing engine. Host register writes (commands) go into a parameterised command FIFO. The FIFO hands them to the engine over a valid/ready stream, one per cycle, whenever the engine accepts. A single 32-bit control and status word is always visible on `status`. It reports the FIFO space the host may still use, two busy indications and two sticky error flags.

The command input is not back-pressured. `cmd_ready` is an advisory view of "not full". A `cmd_valid` beat offered while `cmd_ready` is low is discarded and latches the overflow flag. On the engine side the stream follows normal valid/ready rules: a beat moves when `eng_valid` and `eng_ready` are both high. While `eng_ready` is low, the head beat and its data stay in place. Error flags clear only when the host writes ones to their bit positions through `csr_we`/`csr_wdata`. Every other field of the word is read-only.

Top module: `cmdq_status_ctrl`

## Requirements
- R1: `status[11:0]` equals DEPTH minus the number of queued commands plus SLACK, where SLACK defaults to 8. It updates on the clock edge that pushes or pops. `cmd_ready` is high exactly when fewer than DEPTH commands are queued.
- R2: Commands leave on `eng_data` in the order they were accepted, one per cycle, while `eng_ready` is held high.
- R3: A `cmd_valid` beat arriving when the FIFO holds DEPTH entries at the start of the cycle is dropped. This holds even if a pop happens in the same cycle. The beat sets the overflow flag `status[31]` on that edge.
- R4: A high `rd_err` sets the read-error flag `status[30]` on the next edge.
- R5: Both error flags are sticky. A `csr_we` write with a one in bit 31 clears the overflow flag, and a one in bit 30 clears the read-error flag. Zeros in those bits, and any value in the other bits, have no effect.
- R6: When a flag is set and cleared in the same cycle, the set wins.
- R7: `status[25]` (pipeline busy) is high whenever the FIFO is non-empty or `eng_busy` is high.
- R8: `status[24]` (frame-buffer busy) follows `fb_busy`. It does not depend on FIFO occupancy.
- R9: After reset the FIFO is empty, `eng_valid` is low and `status` reads DEPTH+SLACK in bits 11:0 with every other bit zero.
- R10: While `eng_valid` is high and `eng_ready` is low, `eng_valid` stays high and `eng_data` is unchanged on the next cycle.
- R11: Bits 23:12 and 29:26 of `status` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command write strobe |
| cmd_ready | output | 1 | High while the FIFO has room (advisory) |
| cmd_data | input | CMD_W | Command word |
| eng_valid | output | 1 | Head command available to the engine |
| eng_ready | input | 1 | Engine accepts the head command |
| eng_data | output | CMD_W | Head command word |
| eng_busy | input | 1 | Engine is executing a command |
| fb_busy | input | 1 | Frame-buffer side is busy |
| rd_err | input | 1 | Read-error event pulse |
| csr_we | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data for the status word |
| status | output | 32 | Control and status word |

## Verification
The hardest case to reach from the ports is a command arriving at a full FIFO in the same cycle that the engine pops. A wrong design could accept it because a slot frees up on that edge. To set this up, the bench fills the FIFO with the engine stalled, then raises `cmd_valid` and `eng_ready` together. It then checks that the overflow flag is set and drains the FIFO to confirm that the dropped word never appears. Two other cases need deliberate stimulus. One is a flag set colliding with its write-one-to-clear in the same cycle. The other is a clear write carrying zeros or junk in the remaining bits.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int STAT_W      = 32;
  localparam int FREE_W      = 12;
  localparam int POS_FB_BUSY = 24;
  localparam int POS_PP_BUSY = 25;
  localparam int POS_RD_ERR  = 30;
  localparam int POS_OVF     = 31;
  localparam int ERR_N       = 2;
  localparam int ERR_RD      = 0;
  localparam int ERR_OVF     = 1;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 40,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];
endmodule

// File: rtl/cmdq_err_flags.sv
module cmdq_err_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_status_pack.sv
module cmdq_status_pack
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  count,
  input  logic              fb_busy,
  input  logic              pp_busy,
  input  logic [ERR_N-1:0]  errs,
  output logic [STAT_W-1:0] word
);
  localparam logic [FREE_W-1:0] TOP_FREE = FREE_W'(DEPTH + SLACK);

  always_comb begin
    word                 = '0;
    word[FREE_W-1:0]     = TOP_FREE - FREE_W'(count);
    word[POS_FB_BUSY]    = fb_busy;
    word[POS_PP_BUSY]    = pp_busy;
    word[POS_RD_ERR]     = errs[ERR_RD];
    word[POS_OVF]        = errs[ERR_OVF];
  end
endmodule

// File: rtl/cmdq_status_ctrl.sv
module cmdq_status_ctrl
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 8,
  parameter int CMD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [CMD_W-1:0]  eng_data,
  input  logic              eng_busy,
  input  logic              fb_busy,
  input  logic              rd_err,
  input  logic              csr_we,
  input  logic [STAT_W-1:0] csr_wdata,
  output logic [STAT_W-1:0] status
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             full, push, pop;
  logic [ERR_N-1:0] err_set, err_clr, errs;
  logic             unused_wbits;

  assign full      = (count == CNT_W'(DEPTH));
  assign cmd_ready = !full;
  assign eng_valid = (count != '0);
  assign push      = cmd_valid && !full;
  assign pop       = eng_valid && eng_ready;

  cmdq_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (cmd_data),
    .pop   (pop),
    .dout  (eng_data),
    .count (count)
  );

  always_comb begin
    err_set          = '0;
    err_clr          = '0;
    err_set[ERR_OVF] = cmd_valid && full;
    err_set[ERR_RD]  = rd_err;
    err_clr[ERR_OVF] = csr_we && csr_wdata[POS_OVF];
    err_clr[ERR_RD]  = csr_we && csr_wdata[POS_RD_ERR];
  end

  assign unused_wbits = ^csr_wdata[POS_RD_ERR-1:0];

  cmdq_err_flags #(.N(ERR_N)) u_errs (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (err_clr),
    .flags (errs)
  );

  cmdq_status_pack #(.DEPTH(DEPTH), .SLACK(SLACK)) u_pack (
    .count   (count),
    .fb_busy (fb_busy),
    .pp_busy (eng_valid || eng_busy),
    .errs    (errs),
    .word    (status)
  );
endmodule

// File: rtl/cmdq_status_chk.sv
module cmdq_status_chk
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 8,
  parameter int CMD_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic [CMD_W-1:0]  eng_data,
  input logic              csr_we,
  input logic [1:0]        wclr,
  input logic              rd_err,
  input logic [STAT_W-1:0] status
);
  localparam logic [FREE_W-1:0] LOW_FREE = FREE_W'(SLACK);
  localparam logic [FREE_W-1:0] TOP_FREE = FREE_W'(DEPTH + SLACK);

  a_r3_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> status[POS_OVF]);

  a_r3_ready_vs_free: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == (status[FREE_W-1:0] != LOW_FREE));

  a_r1_free_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    status[FREE_W-1:0] >= LOW_FREE && status[FREE_W-1:0] <= TOP_FREE);

  a_r4_rderr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> status[POS_RD_ERR]);

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[POS_OVF] && !(csr_we && wclr[1]) |=> status[POS_OVF]);

  a_r5_rderr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    status[POS_RD_ERR] && !(csr_we && wclr[0]) |=> status[POS_RD_ERR]);

  a_r7_busy_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> status[POS_PP_BUSY]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_data));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[POS_FB_BUSY-1:FREE_W] == '0 && status[POS_RD_ERR-1:POS_PP_BUSY+1] == '0);
endmodule

bind cmdq_status_ctrl cmdq_status_chk #(.DEPTH(DEPTH), .SLACK(SLACK), .CMD_W(CMD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .eng_valid (eng_valid),
  .eng_ready (eng_ready),
  .eng_data  (eng_data),
  .csr_we    (csr_we),
  .wclr      (csr_wdata[31:30]),
  .rd_err    (rd_err),
  .status    (status)
);

// File: tb/cmdq_status_ctrl_test.sv
module cmdq_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int SLACK = 8;
  localparam int CW    = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [CW-1:0] cmd_data = '0;
  logic          eng_valid;
  logic          eng_ready = 1'b0;
  logic [CW-1:0] eng_data;
  logic          eng_busy = 1'b0;
  logic          fb_busy = 1'b0;
  logic          rd_err = 1'b0;
  logic          csr_we = 1'b0;
  logic [31:0]   csr_wdata = '0;
  logic [31:0]   status;

  int checks = 0;
  int bad    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdq_status_ctrl #(.DEPTH(DEPTH), .SLACK(SLACK), .CMD_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_data(eng_data), .eng_busy(eng_busy), .fb_busy(fb_busy),
    .rd_err(rd_err), .csr_we(csr_we), .csr_wdata(csr_wdata), .status(status)
  );

  typedef struct packed {
    logic       push;
    logic       rdy;
    logic       we;
    logic [1:0] clr;
    logic       rerr;
    logic [7:0] efree;
    logic       eovf;
    logic       erer;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,2'b00,1'b0,8'd11,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,8'd10,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,8'd9, 1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,8'd8, 1'b0,1'b0},
    '{1'b1,1'b0,1'b0,2'b00,1'b0,8'd8, 1'b1,1'b0},
    '{1'b0,1'b0,1'b1,2'b00,1'b0,8'd8, 1'b1,1'b0},
    '{1'b0,1'b0,1'b0,2'b00,1'b1,8'd8, 1'b1,1'b1},
    '{1'b0,1'b1,1'b0,2'b00,1'b0,8'd9, 1'b1,1'b1},
    '{1'b1,1'b1,1'b0,2'b00,1'b0,8'd9, 1'b1,1'b1},
    '{1'b0,1'b0,1'b1,2'b10,1'b0,8'd9, 1'b0,1'b1},
    '{1'b0,1'b0,1'b1,2'b01,1'b1,8'd9, 1'b0,1'b1},
    '{1'b0,1'b0,1'b1,2'b01,1'b0,8'd9, 1'b0,1'b0},
    '{1'b0,1'b1,1'b0,2'b00,1'b0,8'd10,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,2'b00,1'b0,8'd11,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,2'b00,1'b0,8'd12,1'b0,1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_one(input logic [CW-1:0] d);
    cmd_valid = 1'b1;
    cmd_data  = d;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state
    chk("R9 status", 64'(status), 64'h0000_000C);
    chk("R9 eng_valid", 64'(eng_valid), 64'd0);

    // Table: R1 free count, R3 overflow, R4/R5/R6 flags; junk in low write bits for R5
    for (int i = 0; i < NV; i++) begin
      cmd_valid = TBL[i].push;
      cmd_data  = CW'(32'h100 + i);
      eng_ready = TBL[i].rdy;
      csr_we    = TBL[i].we;
      csr_wdata = {TBL[i].clr, 30'h3FFF_FFFF};
      rd_err    = TBL[i].rerr;
      tick();
      chk($sformatf("R1 free row %0d", i), 64'(status[11:0]), 64'(TBL[i].efree));
      chk($sformatf("R3 R5 ovf row %0d", i), 64'(status[31]), 64'(TBL[i].eovf));
      chk($sformatf("R4 R6 rderr row %0d", i), 64'(status[30]), 64'(TBL[i].erer));
      chk($sformatf("R11 reserved row %0d", i), 64'({status[23:12], status[29:26]}), 64'd0);
    end
    cmd_valid = 1'b0; eng_ready = 1'b0; csr_we = 1'b0; csr_wdata = '0; rd_err = 1'b0;

    // R2 / R10 ordering and back-pressure
    push_one(40'hA1);
    push_one(40'hB2);
    push_one(40'hC3);
    chk("R2 head", 64'(eng_data), 64'hA1);
    chk("R7 busy nonempty", 64'(status[25]), 64'd1);
    tick();
    chk("R10 hold valid", 64'(eng_valid), 64'd1);
    chk("R10 hold data", 64'(eng_data), 64'hA1);
    eng_ready = 1'b1;
    tick();
    chk("R2 second", 64'(eng_data), 64'hB2);
    tick();
    chk("R2 third", 64'(eng_data), 64'hC3);
    tick();
    chk("R2 drained", 64'(eng_valid), 64'd0);
    eng_ready = 1'b0;
    chk("R1 free empty", 64'(status[11:0]), 64'd12);

    // R7 / R8 busy bits
    eng_busy = 1'b1; #1;
    chk("R7 eng_busy", 64'(status[25:24]), 64'b10);
    eng_busy = 1'b0; fb_busy = 1'b1; #1;
    chk("R8 fb_busy", 64'(status[25:24]), 64'b01);
    fb_busy = 1'b0; #1;
    chk("R7 R8 idle", 64'(status[25:24]), 64'b00);

    // R3 full FIFO with simultaneous pop
    for (int k = 0; k < DEPTH; k++) push_one(CW'(32'hA0 + k));
    chk("R1 ready low when full", 64'(cmd_ready), 64'd0);
    chk("R1 free full", 64'(status[11:0]), 64'd8);
    cmd_valid = 1'b1; cmd_data = 40'hEE; eng_ready = 1'b1;
    tick();
    cmd_valid = 1'b0;
    chk("R3 ovf on full+pop", 64'(status[31]), 64'd1);
    chk("R3 free after pop", 64'(status[11:0]), 64'd9);
    chk("R2 head after pop", 64'(eng_data), 64'hA1);
    tick(); tick(); tick();
    chk("R3 dropped word absent", 64'(eng_valid), 64'd0);
    eng_ready = 1'b0;

    // R9 reset mid-run clears flags
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    chk("R9 status after reset", 64'(status), 64'h0000_000C);
    tick();
    finish_run();
  end
endmodule